// File: doc/BRIEF.md
# Indexed Configuration Byte Window

This block is a bank of 256 byte-wide configuration registers that a host reaches through only two byte addresses. A write to the lower address (the selector) chooses which register is current. Reads and writes at the upper address (the data port) then reach that register. Reads return data one cycle after the request.

Each register index is either writable or read-only, and the map of writable indices is sparse. Six registers come out of reset holding fixed non-zero values; every other register resets to zero.

The two registers that hold the serial-port base codes are watched. Storing anything other than their expected value raises a sticky per-port flag, which reset alone clears.

A single enable input, driven by a configuration bit in the parent bridge, gates the whole window. While the enable is low, the window claims nothing: reads return 0xFF, writes change nothing, and the selector keeps its value.

Top module: `cfgwin_top`

## Requirements
- R1: After reset the selector is 0x00, `rdata_o` is 0x00 and both `base_flag_o` bits are 0.
- R2: With the window enabled, a write with `addr_sel_i`=0 loads `wdata_i` into the selector.
- R3: A read with `addr_sel_i`=1 returns the register chosen by the selector. A read with `addr_sel_i`=0 returns the selector itself. `rdata_o` changes on the clock edge that samples `rd_en_i` and holds its value while `rd_en_i` is low.
- R4: Data-port writes have no effect when the selector is in any of these sets: 0x00–0xDF, 0xE4–0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB, 0xFD–0xFF.
- R5: A data-port write to any of the indices 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC stores `wdata_i` in that register.
- R6: Reset loads these values: index 0xE0 = 0x3C, 0xE2 = 0x03, 0xE3 = 0xFC, 0xE6 = 0xDE, 0xE7 = 0xFE, 0xE8 = 0xBE. All other indices reset to 0x00.
- R7: A data-port write of a value other than 0xFE to index 0xE7 sets `base_flag_o[0]`. A write of a value other than 0xBE to index 0xE8 sets `base_flag_o[1]`. The value is still stored. Set flags stay set until reset.
- R8: While `win_en_i` is 0, a read returns 0xFF, and writes change neither the selector nor any register.
- R9: When a read and a write hit the data port in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| win_en_i | input | 1 | Window enable from the parent bridge |
| addr_sel_i | input | 1 | 0 selects the selector register, 1 selects the data port |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_en_i` |
| base_flag_o | output | 2 | Sticky flags for unexpected serial-port base codes (bit 0: index 0xE7, bit 1: index 0xE8) |

## Verification
The assertions assume that `win_en_i`, `addr_sel_i`, `wr_en_i`, `rd_en_i` and `wdata_i` hold known values at every clock edge after reset. They do not assume that the read and write strobes are mutually exclusive, so the same-cycle read-and-write case stays legal. The stimulus drives every input on the falling edge from a single process. It returns the strobes to zero between accesses, and it raises both strobes together only in the directed same-cycle case. The enable input changes only between accesses, so each disabled access is entirely inside a disabled window.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [7:0] BASE_A_IDX  = 8'hE7;
    localparam logic [7:0] BASE_A_CODE = 8'hFE;
    localparam logic [7:0] BASE_B_IDX  = 8'hE8;
    localparam logic [7:0] BASE_B_CODE = 8'hBE;
    localparam logic [7:0] IDLE_READ   = 8'hFF;

    // Sparse map of indices that accept data-port writes.
    function automatic logic idx_writable(input int unsigned idx);
        logic [7:0] b;
        b = idx[7:0];
        case (b) inside
            [8'hE0:8'hE3], [8'hE6:8'hE8], [8'hEE:8'hF2],
            8'hF4, 8'hF6, 8'hF8, 8'hFC: idx_writable = 1'b1;
            default:                    idx_writable = 1'b0;
        endcase
    endfunction

    // Values loaded when reset is asserted.
    function automatic logic [7:0] idx_reset_val(input int unsigned idx);
        logic [7:0] b;
        b = idx[7:0];
        case (b)
            8'hE0:   idx_reset_val = 8'h3C;
            8'hE2:   idx_reset_val = 8'h03;
            8'hE3:   idx_reset_val = 8'hFC;
            8'hE6:   idx_reset_val = 8'hDE;
            8'hE7:   idx_reset_val = 8'hFE;
            8'hE8:   idx_reset_val = 8'hBE;
            default: idx_reset_val = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgwin_wprot.sv
module cfgwin_wprot #(
    parameter int unsigned IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [IDX_W-1:0] wdata_i,
    output logic             wr_allow_o,
    output logic [1:0]       base_bad_o
);
    import cfgwin_pkg::*;

    always_comb begin
        wr_allow_o    = idx_writable(int'(idx_i));
        base_bad_o[0] = (idx_i == IDX_W'(BASE_A_IDX)) && (wdata_i != IDX_W'(BASE_A_CODE));
        base_bad_o[1] = (idx_i == IDX_W'(BASE_B_IDX)) && (wdata_i != IDX_W'(BASE_B_CODE));
    end

endmodule

// File: rtl/cfgwin_regfile.sv
module cfgwin_regfile #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_REGS = 256,
    localparam int unsigned AW      = $clog2(NUM_REGS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [AW-1:0]     idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rd_word_o
);
    import cfgwin_pkg::*;

    logic [DATA_W-1:0] mem_d [NUM_REGS];
    logic [DATA_W-1:0] mem_q [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[idx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem_q[i] <= DATA_W'(idx_reset_val(i));
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_word_o = mem_q[idx_i];

    AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> rd_word_o == $past(wdata_i)) else $error("write lost"); // R5

endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned NUM_REGS = 1 << DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              win_en_i,
    input  logic              addr_sel_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [1:0]        base_flag_o
);
    import cfgwin_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] idx;
        logic [DATA_W-1:0] rdata;
        logic [1:0]        flags;
    } win_state_t;

    win_state_t st_d, st_q;

    logic              sel_wr;
    logic              dat_wr;
    logic              wr_allow;
    logic [1:0]        base_bad;
    logic [DATA_W-1:0] rd_word;

    cfgwin_wprot #(.IDX_W(DATA_W)) u_wprot (
        .idx_i      (st_q.idx),
        .wdata_i    (wdata_i),
        .wr_allow_o (wr_allow),
        .base_bad_o (base_bad)
    );

    cfgwin_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (dat_wr && wr_allow),
        .idx_i     (st_q.idx),
        .wdata_i   (wdata_i),
        .rd_word_o (rd_word)
    );

    always_comb begin
        st_d   = st_q;
        sel_wr = win_en_i && wr_en_i && !addr_sel_i;
        dat_wr = win_en_i && wr_en_i && addr_sel_i;
        if (sel_wr) begin
            st_d.idx = wdata_i;
        end
        if (rd_en_i) begin
            if (!win_en_i) begin
                st_d.rdata = DATA_W'(IDLE_READ);
            end else if (addr_sel_i) begin
                st_d.rdata = rd_word;
            end else begin
                st_d.rdata = st_q.idx;
            end
        end
        if (dat_wr && wr_allow) begin
            st_d.flags = st_q.flags | base_bad;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o     = st_q.rdata;
    assign base_flag_o = st_q.flags;

    AST_SEL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_en_i && wr_en_i && !addr_sel_i) |=> st_q.idx == $past(wdata_i)) else $error("selector"); // R2
    AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o)) else $error("rdata moved"); // R3
    AST_RO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dat_wr && !wr_allow) |=> $stable(rd_word)) else $error("read-only changed"); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (base_flag_o != 2'b00) |=> ((base_flag_o & $past(base_flag_o)) == $past(base_flag_o))) else $error("flag cleared"); // R7
    AST_OFF_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !win_en_i) |=> rdata_o == DATA_W'(IDLE_READ)) else $error("disabled read"); // R8
    AST_OFF_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !win_en_i |=> $stable(st_q.idx)) else $error("disabled selector"); // R8

endmodule

// File: tb/tb_cfgwin_top.sv
`timescale 1ns/1ps
module tb_cfgwin_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       win_en = 1'b1;
    logic       addr_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [1:0] flags;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] exp_mem [256];

    always #2 clk = ~clk;

    cfgwin_top dut (
        .clk_i(clk), .rst_ni(rst_n), .win_en_i(win_en), .addr_sel_i(addr_sel),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
        .rdata_o(rdata), .base_flag_o(flags)
    );

    function automatic bit tb_writable(int i);
        return (i >= 'hE0 && i <= 'hE3) || (i >= 'hE6 && i <= 'hE8) ||
               (i >= 'hEE && i <= 'hF2) || i == 'hF4 || i == 'hF6 ||
               i == 'hF8 || i == 'hFC;
    endfunction

    function automatic logic [7:0] tb_reset_val(int i);
        case (i)
            'hE0: return 8'h3C;
            'hE2: return 8'h03;
            'hE3: return 8'hFC;
            'hE6: return 8'hDE;
            'hE7: return 8'hFE;
            'hE8: return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic a, logic [7:0] v);
        @(negedge clk);
        addr_sel = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic a, output logic [7:0] v);
        @(negedge clk);
        addr_sel = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic reg_wr(int idx, logic [7:0] v);
        bus_wr(1'b0, 8'(idx));
        bus_wr(1'b1, v);
        if (win_en && tb_writable(idx)) exp_mem[idx] = v;
    endtask

    task automatic reg_rd(int idx, output logic [7:0] v);
        bus_wr(1'b0, 8'(idx));
        bus_rd(1'b1, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 rdata", rdata, 8'h00);
        check("R1 flags", {6'b0, flags}, 8'h00);
        bus_rd(1'b0, v);
        check("R1 selector", v, 8'h00);
        for (int i = 0; i < 256; i++) begin
            exp_mem[i] = tb_reset_val(i);
            reg_rd(i, v);
            check("R6 reset value", v, exp_mem[i]);
        end
    endtask

    task automatic t_select();
        logic [7:0] v;
        bus_wr(1'b0, 8'hA7);
        bus_rd(1'b0, v);
        check("R2 selector load", v, 8'hA7);
        bus_wr(1'b0, 8'hE6);
        bus_rd(1'b1, v);
        check("R3 data read", v, 8'hDE);
    endtask

    task automatic t_flags();
        logic [7:0] v;
        reg_wr('hE7, 8'hFE);
        reg_wr('hE8, 8'hBE);
        check("R7 expected codes keep flags", {6'b0, flags}, 8'h00);
        reg_wr('hE7, 8'h11);
        check("R7 flag A set", {6'b0, flags}, 8'h01);
        reg_rd('hE7, v);
        check("R7 value stored", v, 8'h11);
        reg_wr('hE7, 8'hFE);
        check("R7 flag A sticky", {6'b0, flags}, 8'h01);
        reg_wr('hE8, 8'h00);
        check("R7 flag B set", {6'b0, flags}, 8'h03);
    endtask

    task automatic t_protect();
        logic [7:0] v;
        int idxs [14] = '{'h00, 'h7F, 'hDF, 'hE4, 'hE5, 'hE9, 'hED,
                          'hF3, 'hF5, 'hF7, 'hF9, 'hFB, 'hFD, 'hFF};
        foreach (idxs[k]) begin
            reg_wr(idxs[k], 8'h5A);
            reg_rd(idxs[k], v);
            check("R4 read-only index", v, exp_mem[idxs[k]]);
        end
    endtask

    task automatic t_writable();
        logic [7:0] v;
        for (int i = 'hE0; i < 256; i++) begin
            if (tb_writable(i)) reg_wr(i, 8'(i) ^ 8'hA5);
        end
        for (int i = 'hE0; i < 256; i++) begin
            reg_rd(i, v);
            check("R5 writable sweep", v, exp_mem[i]);
        end
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        bus_wr(1'b0, 8'hE0);
        @(negedge clk); win_en = 1'b0;
        bus_wr(1'b0, 8'h10);
        bus_wr(1'b1, 8'h77);
        bus_rd(1'b1, v);
        check("R8 disabled data read", v, 8'hFF);
        bus_rd(1'b0, v);
        check("R8 disabled selector read", v, 8'hFF);
        @(negedge clk); win_en = 1'b1;
        bus_rd(1'b0, v);
        check("R8 selector kept", v, 8'hE0);
        bus_rd(1'b1, v);
        check("R8 register unchanged", v, exp_mem['hE0]);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        reg_wr('hF0, 8'h11);
        @(negedge clk);
        addr_sel = 1'b1; wdata = 8'h22; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R9 old value returned", rdata, 8'h11);
        bus_rd(1'b1, v);
        check("R9 new value stored", v, 8'h22);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        reg_rd('hE2, v);
        check("R3 read E2", v, exp_mem['hE2]);
        bus_wr(1'b0, 8'hE3);
        repeat (3) @(negedge clk);
        check("R3 rdata holds", rdata, exp_mem['hE2]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_flags();
        t_protect();
        t_writable();
        t_disabled();
        t_same_cycle();
        t_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule